// File: doc/BRIEF.md
# Byte FIFO with Hysteresis Service Request

This block is a byte-wide first-in first-out buffer that sits between a streaming agent (such as a network port) and a DMA engine. It raises a service request toward the DMA engine with hysteresis. The request rises at one occupancy threshold and falls at another, so the engine moves data in bursts rather than byte by byte. The block is set up as either a transmit buffer or a receive buffer. A transmit buffer asks for refill when it runs low. A receive buffer asks for draining when it fills up.

Each stored byte carries an end-of-packet marker. In packet mode the block counts complete packets. The request then follows whole packets rather than the granularity setting. On transmit, once a whole packet has been loaded, the request stays off until the sending side reports completion.

Control fields (alarm level, 3-bit granularity, packet-mode enable, direction) are quasi-static inputs from a register file. Status is presented as a 32-bit word. The two error flags in that word are sticky and are cleared by write-one-to-clear.

Top module: `pkt_fifo_alarm`

## Requirements
- R1: Bytes and their end-of-packet markers leave the read port in the order they were written. `rd_data` and `rd_eof` show the oldest stored entry, and a read strobe consumes it.
- R2: Two indications track occupancy.
  - Full is reported when DEPTH bytes are held. It is status word bit 18 (bit 13 counted from the MSB).
  - Empty is reported when nothing is held. It is word bit 16 (bit 15 from the MSB).
  - A write removes the empty indication, and only a read removes the full indication.
- R3: A write strobe while the buffer is full is dropped and leaves the contents unchanged.
  - It sets the overflow flag at word bit 20 (bit 11 from the MSB).
  - The flag stays set until a clear write with mask bit 20 set.
- R4: A read strobe while the buffer is empty is dropped and moves no pointer.
  - It sets the underflow flag at word bit 21 (bit 10 from the MSB).
  - The flag stays set until a clear write with mask bit 21 set.
- R5: In receive mode without packet mode, the request works on the occupancy held before each clock edge and becomes visible one cycle after the pointer change.
  - It rises when free space is below the alarm level.
  - It falls when the stored byte count is below the granularity.
- R6: In transmit mode without packet mode, the request works on the occupancy held before each clock edge and becomes visible one cycle after the pointer change.
  - It rises when the stored byte count is below the alarm level.
  - It falls when free space is below four times the granularity.
- R7: Packet-ready is set only while packet mode is enabled and at least one complete packet (one ending in a marked byte) is stored. It is word bit 19 (bit 12 from the MSB). It clears once the last complete packet has been read out.
- R8: In receive packet mode, the request rises when a complete packet is stored and falls once none remain, whatever the granularity.
- R9: In transmit packet mode, accepting a marked byte drops the request. No new request is raised until a `tx_done` pulse arrives, after which the low-level rule (stored count below the alarm level) applies again.
- R10: Status word bit 17 (bit 14 from the MSB) equals the request output. Word bits 15..0 and 31..22 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_vld | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| wr_eof | input | 1 | Marks the written byte as last of a packet |
| rd_vld | input | 1 | Read strobe, consumes the oldest entry |
| rd_data | output | 8 | Oldest stored byte |
| rd_eof | output | 1 | Marker of the oldest stored byte |
| ctl_alarm_lvl | input | $clog2(DEPTH)+1 | Alarm threshold in bytes |
| ctl_gran | input | 3 | Granularity |
| ctl_frame_en | input | 1 | Packet mode enable |
| ctl_is_tx | input | 1 | 1 = transmit buffer, 0 = receive buffer |
| clr_we | input | 1 | Clear strobe for the sticky flags |
| clr_mask | input | 32 | Write-one-to-clear mask aligned with the status word |
| tx_done | input | 1 | Pulse from the sending side reporting packet completion |
| sts_word | output | 32 | Status word |
| svc_req | output | 1 | Service request toward the DMA engine |

## Verification
The properties assume that the direction and packet-mode fields change only while the buffer is idle. The hysteresis and hold checks compare consecutive cycles, and those checks become void if the mode changes under traffic. The bench therefore reprograms these fields only with no strobe active and waits a couple of idle cycles before checking the request. The one exception is a same-instant toggle of packet mode, used to observe packet-ready, which no clock edge sees. The bench also issues `tx_done` only as a single-cycle pulse. It probes overflow and underflow with a lone strobe, so that the assertions that the pointers did not move are not confused by a read and a write in the same cycle.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int STS_W    = 32;
  // Status positions as LSB-0 indices of the 32-bit word (MSB-0 index = 31 - value)
  localparam int STS_UNF  = 21;
  localparam int STS_OVF  = 20;
  localparam int STS_FRDY = 19;
  localparam int STS_FULL = 18;
  localparam int STS_ALM  = 17;
  localparam int STS_EMPT = 16;

  typedef enum logic [1:0] {
    MODE_RX_LVL = 2'b00,
    MODE_TX_LVL = 2'b01,
    MODE_RX_PKT = 2'b10,
    MODE_TX_PKT = 2'b11
  } alarm_mode_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic [7:0]    wr_data,
  input  logic          wr_eof,
  input  logic          rd_vld,
  output logic [7:0]    rd_data,
  output logic          rd_eof,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic          rd_acc_eof,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [8:0]    mem_q [DEPTH];
  logic [CW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] rptr_q, rptr_d;

  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign count = wptr_q - rptr_q;

  assign wr_acc = wr_vld && !full;
  assign rd_acc = rd_vld && !empty;

  assign rd_data    = mem_q[rptr_q[AW-1:0]][7:0];
  assign rd_eof     = mem_q[rptr_q[AW-1:0]][8];
  assign rd_acc_eof = rd_acc && rd_eof;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_acc) wptr_d = wptr_q + CW'(1);
    if (rd_acc) rptr_d = rptr_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem_q[wptr_q[AW-1:0]] <= {wr_eof, wr_data};
  end
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int EW = CW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] lvl,
  input  logic [2:0]    gran,
  input  logic          frame_en,
  input  logic          is_tx,
  input  logic          frames_nz,
  input  logic          eof_wr,
  input  logic          tx_done,
  output logic          alarm,
  output logic          hold
);
  logic [EW-1:0] cnt_x, free_x, lvl_x, gran_x, gran4_x;
  logic          set_c, rel_c;
  logic          alarm_q, alarm_d;
  logic          hold_q, hold_d;
  alarm_mode_e   mode;

  assign cnt_x   = EW'(count);
  assign free_x  = EW'(DEPTH) - cnt_x;
  assign lvl_x   = EW'(lvl);
  assign gran_x  = EW'(gran);
  assign gran4_x = gran_x << 2;
  assign mode    = alarm_mode_e'({frame_en, is_tx});

  always_comb begin
    set_c = 1'b0;
    rel_c = 1'b0;
    unique case (mode)
      MODE_RX_LVL: begin
        set_c = free_x < lvl_x;
        rel_c = cnt_x < gran_x;
      end
      MODE_TX_LVL: begin
        set_c = cnt_x < lvl_x;
        rel_c = free_x < gran4_x;
      end
      MODE_RX_PKT: begin
        set_c = frames_nz;
        rel_c = !frames_nz;
      end
      MODE_TX_PKT: begin
        set_c = (cnt_x < lvl_x) && !hold_q;
        rel_c = hold_q;
      end
      default: begin
        set_c = 1'b0;
        rel_c = 1'b0;
      end
    endcase
  end

  always_comb begin
    alarm_d = alarm_q ? !rel_c : set_c;
    hold_d  = hold_q;
    if (mode != MODE_TX_PKT) hold_d = 1'b0;
    else if (eof_wr)         hold_d = 1'b1;
    else if (tx_done)        hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      hold_q  <= hold_d;
    end
  end

  assign alarm = alarm_q;
  assign hold  = hold_q;
endmodule

// File: rtl/sts_regs.sv
module sts_regs
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_evt,
  input  logic             unf_evt,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_mask,
  input  logic             eof_in,
  input  logic             eof_out,
  input  logic             frame_en,
  input  logic             full,
  input  logic             empty,
  input  logic             alarm,
  output logic             frames_nz,
  output logic [STS_W-1:0] sts_word
);
  logic          ovf_q, ovf_d;
  logic          unf_q, unf_d;
  logic [CW-1:0] pkt_q, pkt_d;

  always_comb begin
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (clr_we && clr_mask[STS_OVF]) ovf_d = 1'b0;
    if (clr_we && clr_mask[STS_UNF]) unf_d = 1'b0;
    if (ovf_evt) ovf_d = 1'b1;
    if (unf_evt) unf_d = 1'b1;
    pkt_d = pkt_q + CW'(eof_in) - CW'(eof_out);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      pkt_q <= '0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      pkt_q <= pkt_d;
    end
  end

  assign frames_nz = (pkt_q != '0);

  always_comb begin
    sts_word           = '0;
    sts_word[STS_UNF]  = unf_q;
    sts_word[STS_OVF]  = ovf_q;
    sts_word[STS_FRDY] = frame_en && frames_nz;
    sts_word[STS_FULL] = full;
    sts_word[STS_ALM]  = alarm;
    sts_word[STS_EMPT] = empty;
  end
endmodule

// File: rtl/pkt_fifo_alarm.sv
module pkt_fifo_alarm
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_vld,
  input  logic [7:0]              wr_data,
  input  logic                    wr_eof,
  input  logic                    rd_vld,
  output logic [7:0]              rd_data,
  output logic                    rd_eof,
  input  logic [$clog2(DEPTH):0]  ctl_alarm_lvl,
  input  logic [2:0]              ctl_gran,
  input  logic                    ctl_frame_en,
  input  logic                    ctl_is_tx,
  input  logic                    clr_we,
  input  logic [31:0]             clr_mask,
  input  logic                    tx_done,
  output logic [31:0]             sts_word,
  output logic                    svc_req
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          rst_meta_q, rst_sync_n;
  logic          wr_acc, rd_acc, rd_acc_eof;
  logic [CW-1:0] cnt_w;
  logic          full_w, empty_w;
  logic          frames_nz_w, alarm_w, hold_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_vld(wr_vld), .wr_data(wr_data), .wr_eof(wr_eof),
    .rd_vld(rd_vld), .rd_data(rd_data), .rd_eof(rd_eof),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .rd_acc_eof(rd_acc_eof),
    .count(cnt_w), .full(full_w), .empty(empty_w)
  );

  alarm_ctrl #(.DEPTH(DEPTH)) u_alarm (
    .clk(clk), .rst_n(rst_sync_n),
    .count(cnt_w), .lvl(ctl_alarm_lvl), .gran(ctl_gran),
    .frame_en(ctl_frame_en), .is_tx(ctl_is_tx),
    .frames_nz(frames_nz_w), .eof_wr(wr_acc && wr_eof), .tx_done(tx_done),
    .alarm(alarm_w), .hold(hold_w)
  );

  sts_regs #(.DEPTH(DEPTH)) u_sts (
    .clk(clk), .rst_n(rst_sync_n),
    .ovf_evt(wr_vld && full_w), .unf_evt(rd_vld && empty_w),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .eof_in(wr_acc && wr_eof), .eof_out(rd_acc_eof),
    .frame_en(ctl_frame_en), .full(full_w), .empty(empty_w), .alarm(alarm_w),
    .frames_nz(frames_nz_w), .sts_word(sts_word)
  );

  assign svc_req = alarm_w;
endmodule

// File: rtl/pkt_fifo_alarm_chk.sv
module pkt_fifo_alarm_chk
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_vld,
  input logic          rd_vld,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] count,
  input logic [CW-1:0] lvl,
  input logic          frame_en,
  input logic          is_tx,
  input logic          clr_we,
  input logic [31:0]   clr_mask,
  input logic [31:0]   sts_word,
  input logic          svc_req,
  input logic          hold
);
  logic [CW:0] free_x;
  assign free_x = (CW+1)'(DEPTH) - (CW+1)'(count);

  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && full && !rd_vld) |=> (count == $past(count)));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_word[STS_OVF] && !(clr_we && clr_mask[STS_OVF])) |=> sts_word[STS_OVF]);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && empty && !wr_vld) |=> (count == $past(count)));

  assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_word[STS_UNF] && !(clr_we && clr_mask[STS_UNF])) |=> sts_word[STS_UNF]);

  assert_rx_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_req && !is_tx && !frame_en && $stable({is_tx, frame_en, lvl}) &&
     (free_x < (CW+1)'(lvl))) |=> svc_req);

  assert_frdy_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_word[STS_FRDY] |-> frame_en);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && frame_en && is_tx && $stable({is_tx, frame_en})) |=> !svc_req);

  assert_alarm_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_word[STS_ALM] == svc_req);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_word[15:0] == 16'h0) && (sts_word[31:22] == 10'h0));
endmodule

bind pkt_fifo_alarm pkt_fifo_alarm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .rd_vld(rd_vld),
  .full(full_w), .empty(empty_w), .count(cnt_w), .lvl(ctl_alarm_lvl),
  .frame_en(ctl_frame_en), .is_tx(ctl_is_tx), .clr_we(clr_we), .clr_mask(clr_mask),
  .sts_word(sts_word), .svc_req(svc_req), .hold(hold_w)
);

// File: tb/pkt_fifo_alarm_bench.sv
module pkt_fifo_alarm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic          clk, rst_n;
  logic          wr_vld, wr_eof, rd_vld, rd_eof;
  logic [7:0]    wr_data, rd_data;
  logic [LW-1:0] ctl_alarm_lvl;
  logic [2:0]    ctl_gran;
  logic          ctl_frame_en, ctl_is_tx, clr_we, tx_done, svc_req;
  logic [31:0]   clr_mask, sts_word;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  pkt_fifo_alarm #(.DEPTH(DEPTH)) u_pkt_fifo_alarm (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_data(wr_data), .wr_eof(wr_eof),
    .rd_vld(rd_vld), .rd_data(rd_data), .rd_eof(rd_eof),
    .ctl_alarm_lvl(ctl_alarm_lvl), .ctl_gran(ctl_gran), .ctl_frame_en(ctl_frame_en),
    .ctl_is_tx(ctl_is_tx), .clr_we(clr_we), .clr_mask(clr_mask), .tx_done(tx_done),
    .sts_word(sts_word), .svc_req(svc_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [7:0] d, logic e);
    wr_vld = 1'b1; wr_data = d; wr_eof = e;
    @(negedge clk);
    wr_vld = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic pop();
    rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic clear(logic [31:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    chk("R2 reset status", sts_word, 32'h0001_0000);
    idle(1);
    chk("R5 reset request", {31'd0, svc_req}, 32'd0);
  endtask

  task automatic t_order();
    push(8'hA1, 1'b0); push(8'hB2, 1'b0); push(8'hC3, 1'b1);
    chk("R2 empty cleared by write", {31'd0, sts_word[16]}, 32'd0);
    chk("R1 first byte", {23'd0, rd_eof, rd_data}, 32'h0A1); pop();
    chk("R1 second byte", {23'd0, rd_eof, rd_data}, 32'h0B2); pop();
    chk("R1 last byte with marker", {23'd0, rd_eof, rd_data}, 32'h1C3); pop();
    chk("R2 empty after drain", {31'd0, sts_word[16]}, 32'd1);
  endtask

  task automatic t_full_ovf();
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i), 1'b0);
    chk("R2 full set", {31'd0, sts_word[18]}, 32'd1);
    chk("R3 no overflow yet", {31'd0, sts_word[20]}, 32'd0);
    push(8'hEE, 1'b0);
    idle(3);
    chk("R3 overflow sticky", {31'd0, sts_word[20]}, 32'd1);
    clear(32'h0010_0000);
    chk("R3 overflow cleared", {31'd0, sts_word[20]}, 32'd0);
    pop();
    chk("R2 full cleared by read", {31'd0, sts_word[18]}, 32'd0);
    chk("R3 dropped write left data", {24'd0, rd_data}, 32'h41);
    for (int i = 1; i < DEPTH; i++) pop();
    chk("R3 no extra byte stored", {31'd0, sts_word[16]}, 32'd1);
    idle(2);
  endtask

  task automatic t_unf();
    pop();
    idle(2);
    chk("R4 underflow sticky", {31'd0, sts_word[21]}, 32'd1);
    push(8'h5A, 1'b1);
    chk("R4 pointers unmoved", {23'd0, rd_eof, rd_data}, 32'h15A);
    pop();
    chk("R4 empty again", {31'd0, sts_word[16]}, 32'd1);
    clear(32'h0020_0000);
    chk("R4 underflow cleared", {31'd0, sts_word[21]}, 32'd0);
  endtask

  task automatic t_rx_alarm();
    for (int i = 0; i < 12; i++) push(8'(i), 1'b0);
    idle(1);
    chk("R5 free 4 no request", {31'd0, svc_req}, 32'd0);
    push(8'h0C, 1'b0);
    idle(1);
    chk("R5 free 3 request", {31'd0, svc_req}, 32'd1);
    chk("R10 alarm bit tracks", {31'd0, sts_word[17]}, 32'd1);
    for (int i = 0; i < 11; i++) pop();
    idle(1);
    chk("R5 held at count 2", {31'd0, svc_req}, 32'd1);
    pop();
    idle(1);
    chk("R5 released at count 1", {31'd0, svc_req}, 32'd0);
    pop();
  endtask

  task automatic t_tx_alarm();
    ctl_is_tx = 1'b1; ctl_gran = 3'd1;
    idle(2);
    chk("R6 request when empty", {31'd0, svc_req}, 32'd1);
    for (int i = 0; i < 12; i++) push(8'(i), 1'b0);
    idle(1);
    chk("R6 held at free 4", {31'd0, svc_req}, 32'd1);
    push(8'h0C, 1'b0);
    idle(1);
    chk("R6 released at free 3", {31'd0, svc_req}, 32'd0);
    for (int i = 0; i < 9; i++) pop();
    idle(1);
    chk("R6 no rise at count 4", {31'd0, svc_req}, 32'd0);
    pop();
    idle(1);
    chk("R6 rise at count 3", {31'd0, svc_req}, 32'd1);
    for (int i = 0; i < 3; i++) pop();
    ctl_is_tx = 1'b0; ctl_gran = 3'd2;
    idle(2);
  endtask

  task automatic t_rx_frame();
    ctl_frame_en = 1'b1; ctl_gran = 3'd7;
    idle(2);
    push(8'h11, 1'b0); push(8'h12, 1'b0);
    idle(1);
    chk("R7 partial packet not ready", {31'd0, sts_word[19]}, 32'd0);
    chk("R8 no request for partial", {31'd0, svc_req}, 32'd0);
    push(8'h13, 1'b1);
    chk("R7 packet ready", {31'd0, sts_word[19]}, 32'd1);
    idle(1);
    chk("R8 request on packet", {31'd0, svc_req}, 32'd1);
    push(8'h21, 1'b0); push(8'h22, 1'b1);
    pop(); pop(); pop();
    idle(1);
    chk("R7 still ready with one packet", {31'd0, sts_word[19]}, 32'd1);
    chk("R8 granularity ignored", {31'd0, svc_req}, 32'd1);
    ctl_frame_en = 1'b0;
    #1;
    chk("R7 ready needs packet mode", {31'd0, sts_word[19]}, 32'd0);
    ctl_frame_en = 1'b1;
    pop(); pop();
    chk("R7 cleared after last packet", {31'd0, sts_word[19]}, 32'd0);
    idle(1);
    chk("R8 released with no packet", {31'd0, svc_req}, 32'd0);
  endtask

  task automatic t_tx_frame();
    ctl_is_tx = 1'b1;
    idle(2);
    chk("R9 low level request", {31'd0, svc_req}, 32'd1);
    push(8'h31, 1'b0); push(8'h32, 1'b1);
    idle(1);
    chk("R9 dropped after packet", {31'd0, svc_req}, 32'd0);
    idle(3);
    chk("R9 held off until done", {31'd0, svc_req}, 32'd0);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    idle(1);
    chk("R9 request after done", {31'd0, svc_req}, 32'd1);
    chk("R10 reserved bits zero", sts_word & 32'hFFC0_FFFF, 32'd0);
    pop(); pop();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_vld = 1'b0; wr_data = '0; wr_eof = 1'b0; rd_vld = 1'b0;
    ctl_alarm_lvl = LW'(4); ctl_gran = 3'd2; ctl_frame_en = 1'b0; ctl_is_tx = 1'b0;
    clr_we = 1'b0; clr_mask = '0; tx_done = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_order();
    t_full_ovf();
    t_unf();
    t_rx_alarm();
    t_tx_alarm();
    t_rx_frame();
    t_tx_frame();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule